// File: doc/BRIEF.md
# Indirect Banked Configuration Port

This block gives a host a small window into two banks of per-channel configuration registers. The host sees only two locations. An 8-bit pointer location picks a bank (primary or secondary channel) and a register index. A 16-bit data location then reads or writes the register that the pointer names. When the pointer's auto-advance flag is set, every data access moves the index on by one. A host can therefore stream a whole bank through the data location after a single pointer write.

Every register comes out of reset holding a fixed default, and some defaults differ between the two banks. Two of the indices can only be written. The stored values of both banks drive configuration outputs all the time. Three single-bit fields of each bank's general register also appear as separate decoded outputs. Read data is registered: it is captured on the edge that samples the read strobe and holds until the next read.

Top module: `cfgwin_top`

## Requirements
- R1: A write to address 1 stores all 8 bits of `bus_wdata[7:0]` in the pointer. A read of address 1 returns the pointer in `bus_rdata[7:0]` with zero in `bus_rdata[15:8]`. Pointer bits 6:4 are kept and read back but have no other effect.
- R2: Pointer bit 3 selects the bank for data accesses at address 0: 0 is the primary bank and 1 is the secondary bank. A data write changes only the selected bank.
- R3: Pointer bits 2:0 select the index. The index map is: 0 command base (16 bit), 1 general config (8 bit), 2 read-ahead count low (8 bit, write-only), 3 read-ahead config (8 bit, write-only), 4 control base (16 bit), 5 data-port timing (8 bit), 6 command-port timing (8 bit).
- R4: After reset the pointer is 0x00 and the registers hold their defaults. Index 0 is 0x01F0 on the primary bank and 0x0170 on the secondary bank. Index 4 is 0x03F6 on the primary bank and 0x0376 on the secondary bank. Index 1 is 0x01, index 5 is 0xF5, index 6 is 0xDE, and indices 2 and 3 are 0x00 on both banks.
- R5: When pointer bit 7 is 1, each data read or data write advances the index by one. Index 6 and index 7 both wrap to 0. When bit 7 is 0, the index stays where it is.
- R6: Indices 0 and 4 store all 16 data bits. The other indices store only `bus_wdata[7:0]` and read back with zero in the upper byte.
- R7: A data read of index 2, 3 or 7 returns 0x0000 and changes no register. A data write to index 7 changes no register.
- R8: `bus_rdata` takes its new value on the clock edge that samples `bus_rd` and keeps it until the next read. If `bus_wr` and `bus_rd` are high together, the write is performed and the read is ignored.
- R9: For each bank b, `port_en_o[b]`, `drv_rst_o[b]` and `dma_en_o[b]` show bits 0, 6 and 7 of that bank's index-1 register.
- R10: Every configuration output shows its register's stored value, with the primary bank in the low slice. The output changes on the edge that performs the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 1 | 0 selects the data location, 1 selects the pointer |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Registered read data |
| cmd_base_o | output | 32 | Index 0 of each bank (secondary in the upper half) |
| ctl_base_o | output | 32 | Index 4 of each bank |
| gen_cfg_o | output | 16 | Index 1 of each bank, 8 bits per bank |
| ra_count_lo_o | output | 16 | Index 2 of each bank, 8 bits per bank |
| ra_cfg_o | output | 16 | Index 3 of each bank, 8 bits per bank |
| data_tim_o | output | 16 | Index 5 of each bank, 8 bits per bank |
| ctl_tim_o | output | 16 | Index 6 of each bank, 8 bits per bank |
| port_en_o | output | 2 | Per-bank I/O port enable (index 1, bit 0) |
| dma_en_o | output | 2 | Per-bank DMA enable (index 1, bit 7) |
| drv_rst_o | output | 2 | Per-bank drive reset request (index 1, bit 6) |

## Verification
The first directed pass streams a whole bank with auto-advance on. This separates correct defaults, correct index order and correct wrap from a design that repeats or skips an index. Single-index writes with all upper data bits set show whether byte and word registers are sized correctly and whether writes stay inside one bank. A second set of patterns covers reads of write-only indices and of index 7, writes to index 7, a write and a read in the same cycle, and idle cycles after a read; these show any side effect or missing hold. A long seeded random mix of pointer writes (with random flag, bank and spare bits), data writes and data reads is compared with a bench model after every operation. It catches errors that only show up when banks and indices are interleaved.

// File: rtl/cfgwin_pkg.sv
package cfgwin_pkg;

    localparam int WORD_W = 16;
    localparam int BYTE_W = 8;
    localparam int IDX_W  = 3;
    localparam int N_IDX  = 7;
    localparam int N_BANK = 2;
    localparam int PTR_W  = 8;

    // pointer layout: flag, spare bits, bank select, index
    typedef struct packed {
        logic             autoinc;
        logic [2:0]       spare;
        logic             bank;
        logic [IDX_W-1:0] idx;
    } ptr_t;

    typedef enum logic [IDX_W-1:0] {
        IX_CMD_BASE = 3'd0,
        IX_GENERAL  = 3'd1,
        IX_RA_LO    = 3'd2,
        IX_RA_CFG   = 3'd3,
        IX_CTL_BASE = 3'd4,
        IX_DATA_TIM = 3'd5,
        IX_CMD_TIM  = 3'd6,
        IX_VOID     = 3'd7
    } idx_e;

    function automatic logic is_word(input logic [IDX_W-1:0] i);
        return (i == IX_CMD_BASE) || (i == IX_CTL_BASE);
    endfunction

    function automatic logic is_readable(input logic [IDX_W-1:0] i);
        return (i != IX_RA_LO) && (i != IX_RA_CFG) && (i != IX_VOID);
    endfunction

    function automatic logic [IDX_W-1:0] next_idx(input logic [IDX_W-1:0] i);
        return (i >= IDX_W'(N_IDX - 1)) ? '0 : i + 1'b1;
    endfunction

    function automatic logic [WORD_W-1:0] reset_val(input logic sec,
                                                    input logic [IDX_W-1:0] i);
        logic [WORD_W-1:0] v;
        case (i)
            IX_CMD_BASE: v = sec ? 16'h0170 : 16'h01F0;
            IX_GENERAL:  v = 16'h0001;
            IX_CTL_BASE: v = sec ? 16'h0376 : 16'h03F6;
            IX_DATA_TIM: v = 16'h00F5;
            IX_CMD_TIM:  v = 16'h00DE;
            default:     v = '0;
        endcase
        return v;
    endfunction

endpackage

// File: rtl/cfgwin_ptr.sv
module cfgwin_ptr
    import cfgwin_pkg::*;
#(
    parameter int PW = PTR_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          ld,
    input  logic [PW-1:0] ld_data,
    input  logic          step,
    output ptr_t          ptr_o
);

    ptr_t q;

    always_ff @(posedge clk) begin
        if (rst) begin
            q <= '0;
        end else if (ld) begin
            q <= ptr_t'(ld_data);
        end else if (step && q.autoinc) begin
            q.idx <= next_idx(q.idx);
        end
    end

    assign ptr_o = q;

    AST_IDX_WRAP: assert property (@(posedge clk) disable iff (rst)
        (step && !ld && q.autoinc && q.idx >= 3'd6) |=> (q.idx == 3'd0)); // R5

    AST_IDX_HOLD: assert property (@(posedge clk) disable iff (rst)
        (step && !ld && !q.autoinc) |=> $stable(q)); // R5

endmodule

// File: rtl/cfgwin_bank.sv
module cfgwin_bank
    import cfgwin_pkg::*;
#(
    parameter logic SEC_BANK = 1'b0,
    parameter int   DW       = WORD_W,
    parameter int   BW       = BYTE_W,
    parameter int   NI       = N_IDX
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   wr_en,
    input  logic [IDX_W-1:0]       wr_idx,
    input  logic [DW-1:0]          wr_data,
    input  logic [IDX_W-1:0]       rd_idx,
    output logic [NI-1:0][DW-1:0]  regs_o,
    output logic [DW-1:0]          rd_val_o
);

    // each register is sized to its own width; byte ones are zero-padded
    for (genvar g = 0; g < NI; g++) begin : g_reg
        localparam logic [IDX_W-1:0] IX = IDX_W'(g);
        localparam int               SW = is_word(IX) ? DW : BW;
        localparam logic [DW-1:0]    RV = reset_val(SEC_BANK, IX);

        logic [SW-1:0] q;

        always_ff @(posedge clk) begin
            if (rst) begin
                q <= RV[SW-1:0];
            end else if (wr_en && wr_idx == IX) begin
                q <= wr_data[SW-1:0];
            end
        end

        if (SW < DW) begin : g_pad
            assign regs_o[g] = {{(DW-SW){1'b0}}, q};
        end else begin : g_full
            assign regs_o[g] = q;
        end
    end

    always_comb begin
        rd_val_o = '0;
        for (int k = 0; k < NI; k++) begin
            if (rd_idx == IDX_W'(k) && is_readable(IDX_W'(k))) begin
                rd_val_o = regs_o[k];
            end
        end
    end

endmodule

// File: rtl/cfgwin_top.sv
module cfgwin_top
    import cfgwin_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        bus_addr,
    input  logic        bus_wr,
    input  logic        bus_rd,
    input  logic [15:0] bus_wdata,
    output logic [15:0] bus_rdata,
    output logic [31:0] cmd_base_o,
    output logic [31:0] ctl_base_o,
    output logic [15:0] gen_cfg_o,
    output logic [15:0] ra_count_lo_o,
    output logic [15:0] ra_cfg_o,
    output logic [15:0] data_tim_o,
    output logic [15:0] ctl_tim_o,
    output logic [1:0]  port_en_o,
    output logic [1:0]  dma_en_o,
    output logic [1:0]  drv_rst_o
);

    localparam logic A_PTR = 1'b1;
    localparam int   PAD_W = WORD_W - PTR_W;

    logic ptr_wr, ptr_rd, dat_wr, dat_rd;
    ptr_t ptr;

    assign ptr_wr = bus_wr &&  (bus_addr == A_PTR);
    assign dat_wr = bus_wr &&  (bus_addr != A_PTR);
    assign ptr_rd = bus_rd && !bus_wr && (bus_addr == A_PTR);
    assign dat_rd = bus_rd && !bus_wr && (bus_addr != A_PTR);

    cfgwin_ptr u_ptr (
        .clk     (clk),
        .rst     (rst),
        .ld      (ptr_wr),
        .ld_data (bus_wdata[PTR_W-1:0]),
        .step    (dat_wr || dat_rd),
        .ptr_o   (ptr)
    );

    logic [N_BANK-1:0][N_IDX-1:0][WORD_W-1:0] bank_regs;
    logic [N_BANK-1:0][WORD_W-1:0]            bank_rd;

    for (genvar b = 0; b < N_BANK; b++) begin : g_bank
        cfgwin_bank #(.SEC_BANK(1'(b))) u_bank (
            .clk      (clk),
            .rst      (rst),
            .wr_en    (dat_wr && (ptr.bank == 1'(b))),
            .wr_idx   (ptr.idx),
            .wr_data  (bus_wdata),
            .rd_idx   (ptr.idx),
            .regs_o   (bank_regs[b]),
            .rd_val_o (bank_rd[b])
        );

        assign cmd_base_o[b*WORD_W +: WORD_W]    = bank_regs[b][IX_CMD_BASE];
        assign ctl_base_o[b*WORD_W +: WORD_W]    = bank_regs[b][IX_CTL_BASE];
        assign gen_cfg_o[b*BYTE_W +: BYTE_W]     = bank_regs[b][IX_GENERAL][BYTE_W-1:0];
        assign ra_count_lo_o[b*BYTE_W +: BYTE_W] = bank_regs[b][IX_RA_LO][BYTE_W-1:0];
        assign ra_cfg_o[b*BYTE_W +: BYTE_W]      = bank_regs[b][IX_RA_CFG][BYTE_W-1:0];
        assign data_tim_o[b*BYTE_W +: BYTE_W]    = bank_regs[b][IX_DATA_TIM][BYTE_W-1:0];
        assign ctl_tim_o[b*BYTE_W +: BYTE_W]     = bank_regs[b][IX_CMD_TIM][BYTE_W-1:0];
        assign port_en_o[b] = bank_regs[b][IX_GENERAL][0];
        assign drv_rst_o[b] = bank_regs[b][IX_GENERAL][6];
        assign dma_en_o[b]  = bank_regs[b][IX_GENERAL][7];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            bus_rdata <= '0;
        end else if (dat_rd) begin
            bus_rdata <= bank_rd[ptr.bank];
        end else if (ptr_rd) begin
            bus_rdata <= {{PAD_W{1'b0}}, ptr};
        end
    end

    AST_PTR_ECHO: assert property (@(posedge clk) disable iff (rst)
        ptr_rd |=> (bus_rdata == {8'h00, $past(ptr)})); // R1

    AST_BANK_ISOLATE: assert property (@(posedge clk) disable iff (rst)
        (dat_wr && !ptr.bank) |=> ($stable(cmd_base_o[31:16]) && $stable(ctl_base_o[31:16])
                                   && $stable(gen_cfg_o[15:8]) && $stable(data_tim_o[15:8]))); // R2

    AST_RESET_STATE: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (cmd_base_o == 32'h0170_01F0 && ctl_base_o == 32'h0376_03F6
                        && data_tim_o == 16'hF5F5 && ctl_tim_o == 16'hDEDE
                        && port_en_o == 2'b11 && ptr == '0)); // R4

    AST_BYTE_UPPER: assert property (@(posedge clk) disable iff (rst)
        (dat_rd && !is_word(ptr.idx)) |=> (bus_rdata[15:8] == 8'h00)); // R6

    AST_HIDDEN_ZERO: assert property (@(posedge clk) disable iff (rst)
        (dat_rd && !is_readable(ptr.idx)) |=> (bus_rdata == 16'h0000)); // R7

    AST_RDATA_HOLD: assert property (@(posedge clk) disable iff (rst)
        !(dat_rd || ptr_rd) |=> $stable(bus_rdata)); // R8

endmodule

// File: tb/tb_cfgwin_top.sv
module tb_cfgwin_top;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_addr = 1'b0;
    logic        bus_wr = 1'b0;
    logic        bus_rd = 1'b0;
    logic [15:0] bus_wdata = '0;
    logic [15:0] bus_rdata;
    logic [31:0] cmd_base_o, ctl_base_o;
    logic [15:0] gen_cfg_o, ra_count_lo_o, ra_cfg_o, data_tim_o, ctl_tim_o;
    logic [1:0]  port_en_o, dma_en_o, drv_rst_o;

    always #2.5 clk = ~clk;

    cfgwin_top dut (
        .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .cmd_base_o(cmd_base_o), .ctl_base_o(ctl_base_o), .gen_cfg_o(gen_cfg_o),
        .ra_count_lo_o(ra_count_lo_o), .ra_cfg_o(ra_cfg_o), .data_tim_o(data_tim_o),
        .ctl_tim_o(ctl_tim_o), .port_en_o(port_en_o), .dma_en_o(dma_en_o),
        .drv_rst_o(drv_rst_o)
    );

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 1'b0;

    logic [15:0] m_reg [2][7];
    logic [7:0]  m_ptr;

    function automatic bit m_isword(input int i);
        return (i == 0) || (i == 4);
    endfunction

    function automatic bit m_readable(input int i);
        return (i == 0) || (i == 1) || (i == 4) || (i == 5) || (i == 6);
    endfunction

    function automatic logic [15:0] m_default(input int b, input int i);
        case (i)
            0: return (b == 1) ? 16'h0170 : 16'h01F0;
            1: return 16'h0001;
            4: return (b == 1) ? 16'h0376 : 16'h03F6;
            5: return 16'h00F5;
            6: return 16'h00DE;
            default: return 16'h0000;
        endcase
    endfunction

    function automatic void m_reset();
        for (int b = 0; b < 2; b++)
            for (int i = 0; i < 7; i++)
                m_reg[b][i] = m_default(b, i);
        m_ptr = 8'h00;
    endfunction

    function automatic void m_step();
        if (m_ptr[7]) m_ptr[2:0] = (m_ptr[2:0] >= 3'd6) ? 3'd0 : m_ptr[2:0] + 3'd1;
    endfunction

    function automatic void m_write(input logic a, input logic [15:0] d);
        int b, i;
        if (a) begin
            m_ptr = d[7:0];
        end else begin
            b = int'(m_ptr[3]);
            i = int'(m_ptr[2:0]);
            if (i < 7) m_reg[b][i] = m_isword(i) ? d : {8'h00, d[7:0]};
            m_step();
        end
    endfunction

    function automatic logic [15:0] m_read(input logic a);
        logic [15:0] v;
        int b, i;
        if (a) return {8'h00, m_ptr};
        b = int'(m_ptr[3]);
        i = int'(m_ptr[2:0]);
        v = (i < 7 && m_readable(i)) ? m_reg[b][i] : 16'h0000;
        m_step();
        return v;
    endfunction

    task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, got, exp);
        end
    endtask

    task automatic check_outs(input string tag);
        check({tag, " cmd_base"}, cmd_base_o, {m_reg[1][0], m_reg[0][0]});
        check({tag, " ctl_base"}, ctl_base_o, {m_reg[1][4], m_reg[0][4]});
        check({tag, " gen_cfg"}, {16'h0, gen_cfg_o}, {16'h0, m_reg[1][1][7:0], m_reg[0][1][7:0]});
        check({tag, " ra_lo"}, {16'h0, ra_count_lo_o}, {16'h0, m_reg[1][2][7:0], m_reg[0][2][7:0]});
        check({tag, " ra_cfg"}, {16'h0, ra_cfg_o}, {16'h0, m_reg[1][3][7:0], m_reg[0][3][7:0]});
        check({tag, " data_tim"}, {16'h0, data_tim_o}, {16'h0, m_reg[1][5][7:0], m_reg[0][5][7:0]});
        check({tag, " ctl_tim"}, {16'h0, ctl_tim_o}, {16'h0, m_reg[1][6][7:0], m_reg[0][6][7:0]});
        check({tag, " R9 fields"}, {26'h0, port_en_o, drv_rst_o, dma_en_o},
              {26'h0, m_reg[1][1][0], m_reg[0][1][0], m_reg[1][1][6], m_reg[0][1][6],
               m_reg[1][1][7], m_reg[0][1][7]});
    endtask

    task automatic bus_write(input logic a, input logic [15:0] d);
        @(negedge clk);
        bus_addr = a; bus_wr = 1'b1; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
        m_write(a, d);
    endtask

    task automatic bus_read(input logic a, input string tag);
        logic [15:0] exp;
        @(negedge clk);
        bus_addr = a; bus_rd = 1'b1;
        @(negedge clk);
        bus_rd = 1'b0;
        exp = m_read(a);
        check(tag, {16'h0, bus_rdata}, {16'h0, exp});
    endtask

    string lbl;

    initial begin
        void'($urandom(32'h1BAD_5EED));
        m_reset();
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // reset state
        check_outs("R4 reset");
        bus_read(1'b1, "R4 R1 pointer after reset");

        // stream primary bank with auto-advance
        bus_write(1'b1, 16'h0080);
        for (int i = 0; i < 7; i++) begin
            lbl = $sformatf("R3 R4 R7 stream primary idx %0d", i);
            bus_read(1'b0, lbl);
        end
        bus_read(1'b1, "R5 wrap after index 6");

        // secondary defaults
        bus_write(1'b1, 16'h0088);
        for (int i = 0; i < 7; i++) begin
            lbl = $sformatf("R2 R4 stream secondary idx %0d", i);
            bus_read(1'b0, lbl);
        end

        // spare pointer bits, no auto-advance
        bus_write(1'b1, 16'hFF70);
        bus_read(1'b1, "R1 spare bits readback");
        bus_read(1'b0, "R5 no advance 1st");
        bus_read(1'b0, "R5 no advance 2nd");

        // byte register and decoded fields
        bus_write(1'b1, 16'h0001);
        bus_write(1'b0, 16'hABC1);
        check_outs("R9 R10 general write");
        bus_read(1'b0, "R6 byte readback");

        // word register on secondary bank
        bus_write(1'b1, 16'h000C);
        bus_write(1'b0, 16'h1234);
        check_outs("R2 R10 secondary word write");
        bus_read(1'b0, "R6 word readback");

        // write-only index
        bus_write(1'b1, 16'h0002);
        bus_write(1'b0, 16'h0155);
        bus_read(1'b0, "R7 write-only reads zero");
        check_outs("R3 R7 write-only kept");

        // index 7 write ignored, wrap from 7
        bus_write(1'b1, 16'h0007);
        bus_write(1'b0, 16'hFFFF);
        check_outs("R7 index 7 write ignored");
        bus_read(1'b0, "R7 index 7 reads zero");
        bus_write(1'b1, 16'h008F);
        bus_write(1'b0, 16'h5A5A);
        check_outs("R7 index 7 auto write ignored");
        bus_read(1'b1, "R5 wrap from index 7");

        // write and read in the same cycle
        bus_write(1'b1, 16'h0005);
        bus_read(1'b1, "R1 pointer before collision");
        @(negedge clk);
        bus_addr = 1'b0; bus_wr = 1'b1; bus_rd = 1'b1; bus_wdata = 16'h0033;
        @(negedge clk);
        bus_wr = 1'b0; bus_rd = 1'b0;
        m_write(1'b0, 16'h0033);
        check("R8 read ignored on collision", {16'h0, bus_rdata}, 32'h0005);
        check_outs("R8 write done on collision");

        // hold across idle cycles
        bus_read(1'b0, "R8 read before idle");
        repeat (4) @(negedge clk);
        check("R8 hold when idle", {16'h0, bus_rdata}, 32'h0033);

        // seeded random mix
        for (int n = 0; n < 1500; n++) begin
            int sel;
            sel = int'($urandom % 10);
            if (sel < 2)      bus_write(1'b1, 16'($urandom));
            else if (sel < 5) bus_write(1'b0, 16'($urandom));
            else if (sel < 9) bus_read(1'b0, "R2 R3 R5 R6 random data read");
            else              bus_read(1'b1, "R1 random pointer read");
            check_outs("R10 random");
        end

        finished = 1'b1;
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog actual=running expected=done");
            $display("test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end

endmodule